// File: doc/BRIEF.md
# Decimating CIC Filter with Gain Stage

This block takes a stream of signed fixed-point samples, scales each one in a gain stage and decimates it by a programmable rate R. The decimator is a cascaded integrator-comb filter whose order can be chosen while the block runs: order one (a plain integrate-and-dump) or order three. The gain stage multiplies each sample by a mantissa between 1.0 and 1.9375 in sixteenths. It then shifts left by the sum of an exponent (0 to 7) and a coarse shift (0 to 63), and drops a fixed number of fraction bits. The result is wrapped into the width the integrators take.

The integrators grow by a fixed number of guard bits and wrap modulo their width. Every R accepted input samples, the comb section emits one value. That value is rounded half-up to an 11-bit window and clamped to the most positive or most negative 11-bit code if it falls outside. The gain terms, the order and R are static configuration inputs that change only while reset is held. Two instances, one per leg, serve a quadrature pair.

Top module: `cic_decim_top`

## Requirements
- R1: Synchronous reset drives out_valid to 0 and out_data to 0, clears every integrator and comb delay, and restarts the decimation count, so that a partial group of samples seen before reset never contributes to a later output.
- R2: For an accepted sample x (in_data as signed integer), mantissa m, exponent e and shift s, the value entering the filter is the low STAGE_W bits, read as signed, of floor(x·(16+m)·2^(e+s) / 2^PRE_DROP).
- R3: With cfg_order = 0 (order one), each output before rounding is the sum of the R most recent gain-stage values, taken over consecutive non-overlapping groups of R accepted samples.
- R4: With cfg_order = 1 (order three), the output for the group ending at accepted sample n is the sum over j of h[j]·g[n−j], where h is the triple self-convolution of a length-R box of ones, and samples before reset count as zero.
- R5: Exactly one output is produced per R accepted samples. A cycle with in_valid = 0 changes nothing. cfg_rate must lie between 4 and 2^(GROWTH/3).
- R6: When the R-th sample of a group is accepted on a rising edge, out_valid is high for the cycle that follows the second rising edge after it.
- R7: The 11-bit result is floor((y + 2^(OUT_LSB−1)) / 2^OUT_LSB), with OUT_LSB = STAGE_W + GROWTH − 11 − HEADROOM (round half up).
- R8: A rounded result above 1023 is output as 1023, and one below −1024 as −1024.
- R9: out_valid is a single-cycle pulse, and out_data holds its last value while out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_order | input | 1 | Filter order: 0 = one, 1 = three |
| cfg_rate | input | GROWTH/3+1 | Decimation rate R |
| cfg_mant | input | 4 | Gain mantissa fraction in sixteenths |
| cfg_exp | input | 3 | Gain exponent, shift 0 to 7 |
| cfg_shift | input | 6 | Coarse gain shift 0 to 63 |
| in_valid | input | 1 | Input sample valid |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | Decimated output valid pulse |
| out_data | output | 11 | Rounded and saturated signed output |

## Verification
The bench builds the block with IN_W = 6, STAGE_W = 10, PRE_DROP = 6, GROWTH = 9 and HEADROOM = 2. That gives a 19-bit accumulator, an output window starting at bit 6 and rates from 4 to 8. At these sizes every rate in range can be swept in both orders. All sixteen mantissas and eight exponents, plus a spread of coarse shifts, can be swept against an exact convolution model. A full-scale constant input at R = 8 in order three exceeds the window, so both saturation limits are reached. A gain-stage value of ±8 at R = 4 lands exactly on a half LSB, which exercises the rounding direction.

// File: rtl/cic_decim_pkg.sv
package cic_decim_pkg;

    localparam int MANT_W     = 4;
    localparam int EXP_W      = 3;
    localparam int SHIFT_W    = 6;
    localparam int OUT_W      = 11;
    localparam int NUM_STAGES = 3;
    localparam int MIN_RATE   = 4;

    typedef enum logic {
        ORD_ONE   = 1'b0,
        ORD_THREE = 1'b1
    } cic_order_e;

    typedef struct packed {
        logic [MANT_W-1:0]  mant;
        logic [EXP_W-1:0]   expo;
        logic [SHIFT_W-1:0] shift;
    } gain_cfg_t;

    // total left shift applied by the gain stage
    function automatic logic [SHIFT_W:0] gain_shift(input gain_cfg_t c);
        return {1'b0, c.shift} + (SHIFT_W+1)'(c.expo);
    endfunction

    // 1.mmmm as a positive integer in sixteenths (sign bit kept clear)
    function automatic logic [MANT_W+1:0] mant_factor(input gain_cfg_t c);
        return {1'b0, 1'b1, c.mant};
    endfunction

endpackage

// File: rtl/cic_gain_stage.sv
module cic_gain_stage
    import cic_decim_pkg::*;
#(
    parameter int IN_W     = 10,
    parameter int STAGE_W  = 20,
    parameter int PRE_DROP = 36
) (
    input  logic                      clk,
    input  logic                      rst,
    input  gain_cfg_t                 cfg,
    input  logic                      in_valid,
    input  logic [IN_W-1:0]           in_data,
    output logic                      s_valid,
    output logic signed [STAGE_W-1:0] s_data
);

    localparam int PROD_W = IN_W + MANT_W + 2 + (2**SHIFT_W - 1) + (2**EXP_W - 1);

    logic signed [PROD_W-1:0]  x_ext;
    logic signed [PROD_W-1:0]  m_ext;
    logic signed [PROD_W-1:0]  prod;
    logic signed [STAGE_W-1:0] stage_d;

    assign x_ext   = {{(PROD_W-IN_W){in_data[IN_W-1]}}, in_data};
    assign m_ext   = {{(PROD_W-MANT_W-2){1'b0}}, mant_factor(cfg)};
    assign prod    = x_ext * m_ext;
    // keep the bits from PRE_DROP upward; upper bits wrap away
    assign stage_d = STAGE_W'((prod <<< gain_shift(cfg)) >>> PRE_DROP);

    always_ff @(posedge clk) begin
        if (rst) begin
            s_valid <= 1'b0;
            s_data  <= '0;
        end else begin
            s_valid <= in_valid;
            if (in_valid) begin
                s_data <= stage_d;
            end
        end
    end

    AST_STAGE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s_valid); // R6

    AST_STAGE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !s_valid); // R5

endmodule

// File: rtl/cic_core.sv
module cic_core
    import cic_decim_pkg::*;
#(
    parameter int STAGE_W = 20,
    parameter int GROWTH  = 36,
    localparam int ACC_W  = STAGE_W + GROWTH,
    localparam int RATE_W = GROWTH / 3 + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  cic_order_e                order,
    input  logic [RATE_W-1:0]         rate,
    input  logic                      s_valid,
    input  logic signed [STAGE_W-1:0] s_data,
    output logic                      d_valid,
    output logic signed [ACC_W-1:0]   d_data
);

    localparam int MAX_RATE = 2**(GROWTH / 3);

    logic [RATE_W-1:0]       cnt;
    logic                    last;
    logic                    fire;
    logic signed [ACC_W-1:0] s_ext;
    logic signed [ACC_W-1:0] acc_q  [NUM_STAGES];
    logic signed [ACC_W-1:0] acc_nx [NUM_STAGES];
    logic signed [ACC_W-1:0] cmb_in [NUM_STAGES];
    logic signed [ACC_W-1:0] cmb    [NUM_STAGES];
    logic signed [ACC_W-1:0] dly_q  [NUM_STAGES];
    logic signed [ACC_W-1:0] tap;

    assign s_ext = {{GROWTH{s_data[STAGE_W-1]}}, s_data};
    assign last  = (cnt == rate - RATE_W'(1));
    assign fire  = s_valid && last;

    // decimation counter over accepted samples
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (s_valid) begin
            cnt <= last ? '0 : cnt + RATE_W'(1);
        end
    end

    // integrator chain: each stage sums the freshly updated value of the one before
    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_int
        localparam bit FIRST = (k == 0);
        logic used;
        assign used = FIRST || (order == ORD_THREE);

        if (k == 0) begin : g_head
            assign acc_nx[k] = acc_q[k] + s_ext;
        end else begin : g_tail
            assign acc_nx[k] = acc_q[k] + acc_nx[k-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q[k] <= '0;
            end else if (s_valid && used) begin
                acc_q[k] <= acc_nx[k];
            end
        end
    end

    assign tap = (order == ORD_THREE) ? acc_nx[NUM_STAGES-1] : acc_nx[0];

    // comb chain, clocked only on decimation points
    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_cmb
        localparam bit FIRST = (k == 0);
        logic used;
        assign used = FIRST || (order == ORD_THREE);

        if (k == 0) begin : g_head
            assign cmb_in[k] = tap;
        end else begin : g_tail
            assign cmb_in[k] = cmb[k-1];
        end
        assign cmb[k] = cmb_in[k] - dly_q[k];

        always_ff @(posedge clk) begin
            if (rst) begin
                dly_q[k] <= '0;
            end else if (fire && used) begin
                dly_q[k] <= cmb_in[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d_valid <= 1'b0;
            d_data  <= '0;
        end else begin
            d_valid <= fire;
            if (fire) begin
                d_data <= (order == ORD_THREE) ? cmb[NUM_STAGES-1] : cmb[0];
            end
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt < rate); // R5

    AST_RATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (32'(rate) >= MIN_RATE) && (32'(rate) <= MAX_RATE)); // R5

    AST_DEC_SOURCE: assert property (@(posedge clk) disable iff (rst)
        d_valid |-> $past(s_valid)); // R6

endmodule

// File: rtl/cic_round_sat.sv
module cic_round_sat
    import cic_decim_pkg::*;
#(
    parameter int ACC_W   = 56,
    parameter int OUT_LSB = 44
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    d_valid,
    input  logic signed [ACC_W-1:0] d_data,
    output logic                    out_valid,
    output logic [OUT_W-1:0]        out_data
);

    localparam int T_W = ACC_W + 1 - OUT_LSB;
    localparam logic signed [ACC_W:0] HALF = $signed((ACC_W+1)'(1) << (OUT_LSB - 1));
    localparam logic [OUT_W-1:0] MAX_CODE = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};
    localparam longint POS_TH = (longint'(1) << (OUT_W - 1 + OUT_LSB)) - (longint'(1) << (OUT_LSB - 1));
    localparam longint NEG_TH = -(longint'(1) << (OUT_W - 1 + OUT_LSB)) - (longint'(1) << (OUT_LSB - 1));

    logic signed [ACC_W:0]   y_ext;
    logic signed [T_W-1:0]   top;
    logic [T_W-OUT_W:0]      hi;
    logic                    ovf;
    logic [OUT_W-1:0]        res;

    assign y_ext = {d_data[ACC_W-1], d_data};
    assign top   = T_W'((y_ext + HALF) >>> OUT_LSB);
    assign hi    = top[T_W-1:OUT_W-1];
    assign ovf   = !((&hi) || !(|hi));
    assign res   = ovf ? (top[T_W-1] ? MIN_CODE : MAX_CODE) : top[OUT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= d_valid;
            if (d_valid) begin
                out_data <= res;
            end
        end
    end

    AST_SAT_POS: assert property (@(posedge clk) disable iff (rst)
        (d_valid && (longint'(d_data) >= POS_TH)) |=> (out_data == MAX_CODE)); // R8

    AST_SAT_NEG: assert property (@(posedge clk) disable iff (rst)
        (d_valid && (longint'(d_data) < NEG_TH)) |=> (out_data == MIN_CODE)); // R8

    AST_OUT_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R9

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data)); // R9

endmodule

// File: rtl/cic_decim_top.sv
module cic_decim_top
    import cic_decim_pkg::*;
#(
    parameter int IN_W     = 10,
    parameter int STAGE_W  = 20,
    parameter int PRE_DROP = 36,
    parameter int GROWTH   = 36,
    parameter int HEADROOM = 1,
    localparam int RATE_W  = GROWTH / 3 + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_order,
    input  logic [RATE_W-1:0]   cfg_rate,
    input  logic [MANT_W-1:0]   cfg_mant,
    input  logic [EXP_W-1:0]    cfg_exp,
    input  logic [SHIFT_W-1:0]  cfg_shift,
    input  logic                in_valid,
    input  logic [IN_W-1:0]     in_data,
    output logic                out_valid,
    output logic [OUT_W-1:0]    out_data
);

    localparam int ACC_W   = STAGE_W + GROWTH;
    localparam int OUT_LSB = ACC_W - OUT_W - HEADROOM;

    gain_cfg_t                 gcfg;
    cic_order_e                order;
    logic                      s_valid;
    logic signed [STAGE_W-1:0] s_data;
    logic                      d_valid;
    logic signed [ACC_W-1:0]   d_data;

    assign gcfg  = '{mant: cfg_mant, expo: cfg_exp, shift: cfg_shift};
    assign order = cic_order_e'(cfg_order);

    cic_gain_stage #(
        .IN_W     (IN_W),
        .STAGE_W  (STAGE_W),
        .PRE_DROP (PRE_DROP)
    ) u_gain (
        .clk      (clk),
        .rst      (rst),
        .cfg      (gcfg),
        .in_valid (in_valid),
        .in_data  (in_data),
        .s_valid  (s_valid),
        .s_data   (s_data)
    );

    cic_core #(
        .STAGE_W (STAGE_W),
        .GROWTH  (GROWTH)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .order   (order),
        .rate    (cfg_rate),
        .s_valid (s_valid),
        .s_data  (s_data),
        .d_valid (d_valid),
        .d_data  (d_data)
    );

    cic_round_sat #(
        .ACC_W   (ACC_W),
        .OUT_LSB (OUT_LSB)
    ) u_round (
        .clk       (clk),
        .rst       (rst),
        .d_valid   (d_valid),
        .d_data    (d_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: tb/cic_decim_top_tb.sv
`timescale 1ns/1ps
module cic_decim_top_tb;

    localparam int IN_W     = 6;
    localparam int STAGE_W  = 10;
    localparam int PRE_DROP = 6;
    localparam int GROWTH   = 9;
    localparam int HEADROOM = 2;
    localparam int RATE_W   = GROWTH / 3 + 1;
    localparam int OUT_LSB  = STAGE_W + GROWTH - 11 - HEADROOM;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_order = 1'b0;
    logic [RATE_W-1:0] cfg_rate = RATE_W'(4);
    logic [3:0]        cfg_mant = '0;
    logic [2:0]        cfg_exp = '0;
    logic [5:0]        cfg_shift = '0;
    logic              in_valid = 1'b0;
    logic [IN_W-1:0]   in_data = '0;
    logic              out_valid;
    logic [10:0]       out_data;

    int     n_chk = 0;
    int     n_fail = 0;
    int     cyc = 0;
    bit     done = 1'b0;
    string  cur_tag = "R3";
    longint exp_val_q[$];
    int     exp_edge_q[$];
    int     last_out = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cic_decim_top #(
        .IN_W(IN_W), .STAGE_W(STAGE_W), .PRE_DROP(PRE_DROP),
        .GROWTH(GROWTH), .HEADROOM(HEADROOM)
    ) u_dut (
        .clk(clk), .rst(rst), .cfg_order(cfg_order), .cfg_rate(cfg_rate),
        .cfg_mant(cfg_mant), .cfg_exp(cfg_exp), .cfg_shift(cfg_shift),
        .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    function automatic longint gain_model(input int x, input int m, input int e, input int sh);
        logic signed [127:0] p;
        p = x;
        p = p * (16 + m);
        p = p <<< (e + sh);
        p = p >>> PRE_DROP;
        return longint'($signed(p[STAGE_W-1:0]));
    endfunction

    function automatic longint round_model(input longint y);
        longint t;
        t = (y + (longint'(1) << (OUT_LSB - 1))) >>> OUT_LSB;
        if (t > 1023) t = 1023;
        if (t < -1024) t = -1024;
        return t;
    endfunction

    // output monitor: value (R3/R4/R7/R8 per case) and timing (R6)
    always @(negedge clk) begin
        if (!rst && !done && out_valid) begin
            if (exp_val_q.size() == 0) begin
                check(1'b0, "R5 unexpected output", longint'($signed(out_data)), 0);
            end else begin
                longint ev;
                int     ee;
                ev = exp_val_q.pop_front();
                ee = exp_edge_q.pop_front();
                check(longint'($signed(out_data)) == ev, cur_tag, longint'($signed(out_data)), ev);
                check(cyc == ee, "R6 latency edge", cyc, ee);
                last_out = int'($signed(out_data));
            end
        end
    end

    task automatic run_case(input int ordr, input int r, input int m, input int e, input int sh,
                            input int ns, input bit cmode, input int xc, input bit gaps,
                            input string tag);
        longint g[256];
        longint h[64];
        int     len;
        int     i;
        in_valid  = 1'b0;
        rst       = 1'b1;
        cfg_order = (ordr == 3);
        cfg_rate  = RATE_W'(r);
        cfg_mant  = 4'(m);
        cfg_exp   = 3'(e);
        cfg_shift = 6'(sh);
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
        check(out_data == '0, "R1 reset data", out_data, 0);
        cur_tag   = tag;
        last_out  = 0;
        // stage values
        for (int k = 0; k < ns; k++) begin
            int x;
            x = cmode ? xc : (((k * 29 + (m + e + sh + r) * 13 + (k * k) % 7) % 64) - 32);
            g[k] = gain_model(x, m, e, sh);
        end
        // impulse response
        for (int j = 0; j < 64; j++) h[j] = 0;
        if (ordr == 3) begin
            len = 3 * r - 2;
            for (int a = 0; a < r; a++)
                for (int b = 0; b < r; b++)
                    for (int c = 0; c < r; c++)
                        h[a + b + c] = h[a + b + c] + 1;
        end else begin
            len = r;
            for (int j = 0; j < r; j++) h[j] = 1;
        end
        for (int k = 1; k <= ns / r; k++) begin
            longint y;
            int n;
            n = k * r - 1;
            y = 0;
            for (int j = 0; j < len; j++)
                if (n - j >= 0) y = y + h[j] * g[n - j];
            exp_val_q.push_back(round_model(y));
        end
        rst = 1'b0;
        i = 0;
        while (i < ns) begin
            @(negedge clk);
            if (gaps && (cyc % 3 == 0)) begin
                in_valid = 1'b0;
                in_data  = '0;
            end else begin
                int x;
                x = cmode ? xc : (((i * 29 + (m + e + sh + r) * 13 + (i * i) % 7) % 64) - 32);
                in_valid = 1'b1;
                in_data  = IN_W'(x);
                if (i % r == r - 1) exp_edge_q.push_back(cyc + 1 + 2);
                i++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = '0;
        repeat (6) @(negedge clk);
        check(exp_val_q.size() == 0, "R5 output count", exp_val_q.size(), 0);
        check(int'($signed(out_data)) == last_out, "R9 hold while idle", $signed(out_data), last_out);
        exp_val_q.delete();
        exp_edge_q.delete();
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // half-LSB rounding: g=+8 and g=-8, four per group -> +/-32 at OUT_LSB 6
        run_case(1, 4, 0, 0, 5, 16, 1'b1, 1, 1'b0, "R7 round up");
        run_case(1, 4, 0, 0, 5, 16, 1'b1, -1, 1'b0, "R7 round half toward plus");
        // partial group left before reset, next case must start clean (R1)
        run_case(1, 4, 5, 2, 1, 18, 1'b0, 0, 1'b1, "R3 with gaps R5");
        run_case(3, 4, 5, 2, 1, 16, 1'b0, 0, 1'b0, "R4 after partial R1");
        // every legal rate in both orders
        for (int r = 4; r <= 8; r++) begin
            run_case(1, r, (r * 3) % 16, r % 8, 0, 6 * r, 1'b0, 0, bit'(r % 2), "R3 rate sweep");
            run_case(3, r, (r * 3) % 16, r % 8, 0, 6 * r, 1'b0, 0, bit'(r % 2), "R4 rate sweep");
        end
        // gain stage sweeps
        for (int m = 0; m < 16; m++)
            run_case(1, 4, m, 1, 0, 8, 1'b0, 0, 1'b0, "R2 mantissa");
        for (int e = 0; e < 8; e++)
            run_case(3, 5, 7, e, 0, 10, 1'b0, 0, 1'b1, "R2 exponent");
        run_case(1, 6, 2, 0, 0, 12, 1'b0, 0, 1'b0, "R2 shift");
        run_case(1, 6, 2, 0, 1, 12, 1'b0, 0, 1'b0, "R2 shift");
        run_case(1, 6, 2, 0, 3, 12, 1'b0, 0, 1'b0, "R2 shift");
        run_case(1, 6, 2, 3, 4, 12, 1'b0, 0, 1'b0, "R2 shift wrap");
        run_case(1, 6, 2, 7, 10, 12, 1'b0, 0, 1'b0, "R2 shift wrap");
        run_case(1, 6, 2, 7, 63, 12, 1'b0, 0, 1'b0, "R2 shift wrap");
        // saturation at both limits
        run_case(3, 8, 15, 0, 5, 32, 1'b1, 31, 1'b0, "R8 positive limit");
        run_case(3, 8, 15, 0, 5, 32, 1'b1, -32, 1'b0, "R8 negative limit");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule